// File: doc/BRIEF.md
# Bidirectional Short-Circuit Fault Sequencer

This block sequences the gate drive of a solid-state power switch built from two FETs in series. It reads digital flags from external fast comparators: a primary overcurrent flag and a higher-threshold (steep di/dt) flag for each current direction. When a primary flag fires, it does not cut the switch at once. It drops both gates to a reduced, voltage-clamped drive and starts two timeouts in parallel. The shorter timeout covers a short that is already present at switch-on. The longer one covers a fault that appears while the switch is conducting.

When the shorter timeout expires, the block re-checks the higher threshold. If that threshold is exceeded, both FETs are cut at once. Otherwise the decision waits for the longer timeout. At that point a short that is still present trips the switch, and a short that has cleared returns the switch to full drive with no trip. A trip latches, stores a fault code and holds until an explicit clear.

A health-test mode asks the comparators to move their thresholds while load current flows. A detection during the test only proves that the path works, so it raises a pass pulse and does not trip the switch. If no detection arrives within a programmed window, a sticky fail flag is set.

Top module: `sc_fault_seq`

## Requirements
- R1: While reset is asserted, both gate outputs are off (2'b00). The outputs trip_o, fault_code_o, thr_test_o, test_pass_o and test_fail_o are all 0.
- R2: Gate encoding: 2'b00 is off, 2'b01 is weak and 2'b10 is full. With the switch off and arm_i high at a clock edge, both gates become full after that edge. With arm_i low at an edge while the gates are full or weak, both gates go off without a trip.
- R3: With the gates full and either primary flag high at an edge (outside a health-test session), both gates go weak after that edge. Both timeouts load at that edge. A timeout value of 0 counts as 1.
- R4: Let k be the edge where weak mode starts, with N1 = max(t_ton_i, 1) and N2 = max(t_ful_i, 1). If N1 <= N2 and either high flag is high at edge k+N1, the switch trips after that edge with fault_code_o bit 1 set. If N1 = N2, this high-di/dt check takes priority over the decision of R5 and R6.
- R5: If no trip occurred through R4 and a primary flag is high at edge k+N2, the switch trips after that edge with fault_code_o bit 1 clear.
- R6: If no trip occurred through R4 and both primary flags are low at edge k+N2, the gates return to full after that edge and trip_o stays 0.
- R7: fault_code_o bit 0 is 0 when weak mode began at the first edge after switch-on (a turn-on short). It is 1 for a fault under load.
- R8: Primary flags that toggle during weak mode do not restart the timeouts. Only the flag level at edge k+N2 decides the outcome.
- R9: A trip forces both gates off and keeps trip_o and fault_code_o stable. arm_i is ignored until clear_i is high at an edge. After that edge the switch is off and fault_code_o and test_fail_o are 0.
- R10: With the gates full, a rising test_en_i starts a session at an edge s, and thr_test_o is high after that edge. A primary flag at edge s+d (1 <= d <= W, where W = max(test_win_i, 1)) gives a one-cycle test_pass_o pulse after that edge. The gates stay full and the session ends.
- R11: If no primary flag arrives by edge s+W, test_fail_o is set after that edge and stays set until clear_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Switch-on command |
| oc_pos_i | input | 1 | Primary overcurrent flag, forward direction |
| oc_neg_i | input | 1 | Primary overcurrent flag, reverse direction |
| hi_pos_i | input | 1 | High-threshold flag, forward direction |
| hi_neg_i | input | 1 | High-threshold flag, reverse direction |
| t_ton_i | input | 16 | Turn-on short timeout in cycles |
| t_ful_i | input | 16 | Fault-under-load timeout in cycles |
| test_en_i | input | 1 | Health-test request |
| test_win_i | input | 16 | Health-test window in cycles |
| clear_i | input | 1 | Releases a trip and clears the sticky flags |
| gate_a_o | output | 2 | Drive code, first FET |
| gate_b_o | output | 2 | Drive code, second FET |
| trip_o | output | 1 | Latched trip |
| fault_code_o | output | 2 | Bit 1: high di/dt path; bit 0: under-load fault |
| thr_test_o | output | 1 | Asks the comparators to shift their thresholds |
| test_pass_o | output | 1 | One-cycle pass pulse |
| test_fail_o | output | 1 | Sticky test failure |

## Verification
The high-di/dt re-check and the final timeout decision can land on the same edge. This happens when both timeouts are programmed equal, including the case where both are 0 and therefore count as 1. The bench provokes this with both high and primary flags asserted at that edge and expects a trip with the di/dt bit set. In a health-test session, a detection can also land on the edge where the window expires. The bench places the detection exactly at edge s+W and expects a pass pulse and no fail flag.

// File: rtl/sc_fault_pkg.sv
package sc_fault_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_ON, ST_WEAK, ST_TRIP} st_e;
  typedef enum logic [1:0] {GD_OFF = 2'b00, GD_WEAK = 2'b01, GD_FULL = 2'b10} gd_e;
endpackage

// File: rtl/sc_dn_timer.sv
module sc_dn_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] val_i,
  output logic         exp_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (load_i)                       cnt_q <= (val_i == '0) ? ONE : val_i;
    else if (run_i && cnt_q != '0)         cnt_q <= cnt_q - ONE;
  end

  // fires on the Nth run edge after load
  assign exp_o = run_i && (cnt_q == ONE);
endmodule

// File: rtl/sc_fault_seq.sv
module sc_fault_seq
  import sc_fault_pkg::*;
#(
  parameter int TW = 16,
  parameter int WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          oc_pos_i,
  input  logic          oc_neg_i,
  input  logic          hi_pos_i,
  input  logic          hi_neg_i,
  input  logic [TW-1:0] t_ton_i,
  input  logic [TW-1:0] t_ful_i,
  input  logic          test_en_i,
  input  logic [WW-1:0] test_win_i,
  input  logic          clear_i,
  output logic [1:0]    gate_a_o,
  output logic [1:0]    gate_b_o,
  output logic          trip_o,
  output logic [1:0]    fault_code_o,
  output logic          thr_test_o,
  output logic          test_pass_o,
  output logic          test_fail_o
);
  localparam int NT = 2;  // 0: turn-on short, 1: fault under load

  st_e         st_q, st_d;
  logic        oc, hi;
  logic        fresh_q, type_q, type_d;
  logic [1:0]  code_q, code_d;
  logic        ld_fault;
  logic [NT-1:0]        t_exp;
  logic [NT-1:0][TW-1:0] t_lim;
  logic        sess_q, done_q, sess_start, sess_pass, sess_fail, w_exp;
  logic        pass_q, fail_q;

  assign oc = oc_pos_i | oc_neg_i;
  assign hi = hi_pos_i | hi_neg_i;
  assign t_lim[0] = t_ton_i;
  assign t_lim[1] = t_ful_i;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    sc_dn_timer #(.W(TW)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(ld_fault),
      .run_i (st_q == ST_WEAK),
      .val_i (t_lim[g]),
      .exp_o (t_exp[g])
    );
  end

  sc_dn_timer #(.W(WW)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sess_start),
    .run_i (sess_q),
    .val_i (test_win_i),
    .exp_o (w_exp)
  );

  always_comb begin
    st_d     = st_q;
    type_d   = type_q;
    code_d   = code_q;
    ld_fault = 1'b0;
    unique case (st_q)
      ST_OFF:  if (arm_i) st_d = ST_ON;
      ST_ON: begin
        if (!arm_i) st_d = ST_OFF;
        else if (oc && !sess_q) begin
          st_d     = ST_WEAK;
          ld_fault = 1'b1;
          type_d   = !fresh_q;
        end
      end
      ST_WEAK: begin
        if (!arm_i) st_d = ST_OFF;
        else if (t_exp[0] && hi) begin
          st_d   = ST_TRIP;
          code_d = {1'b1, type_q};
        end else if (t_exp[1]) begin
          if (oc) begin
            st_d   = ST_TRIP;
            code_d = {1'b0, type_q};
          end else st_d = ST_ON;
        end
      end
      ST_TRIP: if (clear_i) begin
        st_d   = ST_OFF;
        code_d = 2'b00;
      end
      default: st_d = ST_OFF;
    endcase
  end

  assign sess_start = (st_q == ST_ON) && arm_i && !oc && test_en_i && !sess_q && !done_q;
  assign sess_pass  = sess_q && (st_q == ST_ON) && arm_i && test_en_i && oc;
  assign sess_fail  = sess_q && (st_q == ST_ON) && arm_i && test_en_i && !oc && w_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      fresh_q <= 1'b0;
      type_q  <= 1'b0;
      code_q  <= 2'b00;
      sess_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      fresh_q <= (st_q == ST_OFF) && arm_i;
      type_q  <= type_d;
      code_q  <= code_d;
      pass_q  <= sess_pass;
      fail_q  <= clear_i ? 1'b0 : (fail_q | sess_fail);
      if (sess_start) sess_q <= 1'b1;
      else if (sess_pass || sess_fail || !test_en_i || st_q != ST_ON || !arm_i) sess_q <= 1'b0;
      if (!test_en_i) done_q <= 1'b0;
      else if (sess_pass || sess_fail) done_q <= 1'b1;
    end
  end

  gd_e gd;
  always_comb begin
    unique case (st_q)
      ST_ON:   gd = GD_FULL;
      ST_WEAK: gd = GD_WEAK;
      default: gd = GD_OFF;
    endcase
  end

  assign gate_a_o     = gd;
  assign gate_b_o     = gd;
  assign trip_o       = (st_q == ST_TRIP);
  assign fault_code_o = code_q;
  assign thr_test_o   = sess_q;
  assign test_pass_o  = pass_q;
  assign test_fail_o  = fail_q;
endmodule

// File: rtl/sc_fault_seq_chk.sv
module sc_fault_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        arm_i,
  input logic        oc_pos_i,
  input logic        oc_neg_i,
  input logic        clear_i,
  input logic [1:0]  gate_a_o,
  input logic [1:0]  gate_b_o,
  input logic        trip_o,
  input logic [1:0]  fault_code_o,
  input logic        test_pass_o,
  input logic        test_fail_o
);
  assert_weak_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_a_o == 2'b01 && $past(gate_a_o) == 2'b10) |-> $past(oc_pos_i | oc_neg_i));

  assert_trip_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clear_i) |=> (trip_o && $stable(fault_code_o)));

  assert_trip_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> (gate_a_o == 2'b00 && gate_b_o == 2'b00));

  assert_pass_no_trip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_pass_o |-> (gate_a_o == 2'b10 && !trip_o));

  assert_fail_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_fail_o && !clear_i) |=> test_fail_o);

  assert_arm_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !trip_o) |=> (gate_a_o == 2'b00 || $past(gate_a_o) == 2'b00));
endmodule

bind sc_fault_seq sc_fault_seq_chk u_chk (.*);

// File: tb/sim_sc_fault_seq.sv
module sim_sc_fault_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 0, oc_pos = 0, oc_neg = 0, hi_pos = 0, hi_neg = 0, test_en = 0, clear = 0;
  logic [15:0] t_ton = 0, t_ful = 0, test_win = 0;
  logic [1:0] gate_a, gate_b, code;
  logic trip, thr_test, pass, fail;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_fault_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm),
    .oc_pos_i(oc_pos), .oc_neg_i(oc_neg), .hi_pos_i(hi_pos), .hi_neg_i(hi_neg),
    .t_ton_i(t_ton), .t_ful_i(t_ful), .test_en_i(test_en), .test_win_i(test_win),
    .clear_i(clear), .gate_a_o(gate_a), .gate_b_o(gate_b), .trip_o(trip),
    .fault_code_o(code), .thr_test_o(thr_test), .test_pass_o(pass), .test_fail_o(fail)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int eff(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int exp_code(int kind, int n1, int n2, int ty);
    if (kind == 0 && n1 <= n2) return 2 + ty;
    return ty;
  endfunction

  task automatic go_on();
    oc_pos = 0; oc_neg = 0; hi_pos = 0; hi_neg = 0;
    clear = 1; arm = 0; step();
    clear = 0; arm = 1; step();
    step();
    chk("R2 full after arm", gate_a, 2);
  endtask

  // kind 0: high flag at N1, 1: short persists, 2: short clears
  task automatic fault_case(int t1, int t2, int kind, bit fresh, bit noise);
    int n1, n2, endj, ty;
    bit dir, ocv;
    n1 = eff(t1); n2 = eff(t2);
    t_ton = 16'(t1); t_ful = 16'(t2);
    ty = fresh ? 0 : 1;
    dir = 1'($urandom_range(0, 1));
    if (fresh) begin
      arm = 0; step();
      arm = 1; oc_pos = dir; oc_neg = !dir; step();
      chk("R7 full first cycle", gate_a, 2);
    end else begin
      oc_pos = dir; oc_neg = !dir;
    end
    step();
    chk("R3 weak entry", gate_a, 1);
    chk("R3 gate b weak", gate_b, 1);
    endj = (kind == 0 && n1 <= n2) ? n1 : n2;
    for (int j = 1; j <= endj; j++) begin
      if (j == endj) ocv = (kind != 2);
      else ocv = noise ? 1'($urandom_range(0, 1)) : (kind != 2);
      oc_pos = ocv & dir; oc_neg = ocv & !dir;
      hi_pos = (kind == 0 && j == n1) & !dir;
      hi_neg = (kind == 0 && j == n1) & dir;
      step();
      if (j < endj) chk("R8 still weak", gate_a, 1);
    end
    oc_pos = 0; oc_neg = 0; hi_pos = 0; hi_neg = 0;
    if (kind == 2) begin
      chk("R6 ride-through full", gate_a, 2);
      chk("R6 no trip", trip, 0);
    end else begin
      chk("R4/R5 trip", trip, 1);
      chk("R4/R5/R7 code", code, exp_code(kind, n1, n2, ty));
      chk("R9 gates off", gate_b, 0);
    end
    go_on();
  endtask

  task automatic test_case(int w, int d);
    int wn;
    wn = eff(w);
    test_win = 16'(w);
    oc_pos = 0; oc_neg = 0;
    test_en = 1; step();
    chk("R10 thr_test on", thr_test, 1);
    if (d > 0) begin
      for (int j = 1; j <= d; j++) begin
        oc_neg = (j == d);
        step();
        if (j < d) chk("R10 no early pass", pass, 0);
      end
      oc_neg = 0;
      chk("R10 pass pulse", pass, 1);
      chk("R10 gate stays full", gate_a, 2);
      chk("R10 no trip", trip, 0);
      chk("R11 no fail on pass", fail, 0);
      step();
      chk("R10 pulse one cycle", pass, 0);
      chk("R10 thr_test off", thr_test, 0);
    end else begin
      for (int j = 1; j <= wn; j++) begin
        step();
        if (j == wn - 1) chk("R11 fail not early", fail, 0);
      end
      chk("R11 fail set", fail, 1);
      chk("R11 gate full", gate_a, 2);
      test_en = 0; step(); step();
      chk("R11 fail sticky", fail, 1);
      go_on();
      chk("R9 clear resets fail", fail, 0);
    end
    test_en = 0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 gate a", gate_a, 0);
    chk("R1 gate b", gate_b, 0);
    chk("R1 trip", trip, 0);
    chk("R1 code", code, 0);
    chk("R1 thr", thr_test, 0);
    chk("R1 pass", pass, 0);
    chk("R1 fail", fail, 0);
    rst_n = 1;
    step();
    chk("R2 off without arm", gate_a, 0);
    go_on();

    // directed corners
    fault_case(0, 0, 0, 0, 0);    // R4 zero counts as one, same-edge priority
    fault_case(5, 5, 0, 1, 0);    // R4 equal timeouts, R7 turn-on
    fault_case(10, 4, 0, 0, 0);   // R4 N1 > N2 falls to R5
    fault_case(3, 8, 1, 1, 0);    // R5 R7
    fault_case(3, 9, 2, 0, 1);    // R6 R8 noise
    fault_case(0, 0, 2, 0, 0);    // R6 zero timeouts

    // R2 arm off during weak, no trip
    oc_pos = 1; t_ton = 20; t_ful = 30; step();
    chk("R2 weak", gate_a, 1);
    oc_pos = 0; arm = 0; step();
    chk("R2 off from weak", gate_a, 0);
    chk("R2 no trip", trip, 0);
    go_on();

    // R9 arm ignored during trip
    t_ton = 2; t_ful = 3; oc_neg = 1; step();
    for (int j = 0; j < 3; j++) step();
    oc_neg = 0;
    chk("R9 tripped", trip, 1);
    arm = 0; step(); arm = 1; step(); step();
    chk("R9 arm ignored", gate_a, 0);
    chk("R9 code held", code, 1);
    clear = 1; step();
    clear = 0;
    chk("R9 trip released", trip, 0);
    chk("R9 code cleared", code, 0);
    chk("R9 off after clear", gate_a, 0);
    step();
    chk("R2 rearm full", gate_a, 2);
    step();

    // health test
    test_case(6, 3);
    test_case(4, 4);   // detection on window-expiry edge
    test_case(0, 1);
    test_case(5, 0);
    test_case(0, 0);

    // random
    for (int i = 0; i < 40; i++) begin
      fault_case($urandom_range(0, 30), $urandom_range(0, 40),
                 $urandom_range(0, 2), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 10; i++) begin
      int w;
      w = $urandom_range(1, 20);
      test_case(w, $urandom_range(0, w));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule